// File: doc/BRIEF.md
# Eight-bit timer with clear-on-compare mode

This block is an 8-bit up-counter that advances on ticks from a prescaler. The prescaler divides the system clock by 1, 8, 64, 256 or 1024, or stops the timer. In free-running mode the counter runs from 0x00 to 0xFF and wraps. In clear-on-compare mode the value held in the compare register sets the top of the count. When the counter reaches that value it returns to zero on the next tick. The counter can then produce a square wave on a single output pin by inverting that pin on every compare match.

Software uses plain write strobes to load the counter or the compare register, and it can do this at any time. Two sticky flags report counter wrap-around and compare matches. Each flag is cleared by its own acknowledge input. The compare register has no shadow copy. A new value takes effect on the cycle after it is written. If that value is below the current count, the match is missed until the counter wraps.

Top module: `ctc_timer`

## Requirements
- R1: After reset the counter, the compare register, both flags and the waveform output are all 0.
- R2: With mode code 0 (codes 1 and 3 act the same way), each tick adds one to the counter. It wraps from 0xFF to 0x00 and is never cleared by a compare match.
- R3: With mode code 2, a tick on which the count equals the compare register makes the count 0 on the next cycle. Other ticks add one.
- R4: The overflow flag is set in the cycle after a tick on which the count is 0xFF, in both modes. Only the overflow acknowledge input clears it. If a set and an acknowledge fall in the same cycle, the set wins.
- R5: The compare flag is set in the cycle after a tick on which the count equals the compare register, in every mode. Only the compare acknowledge input clears it. If a set and an acknowledge fall in the same cycle, the set wins.
- R6: A compare write takes effect on the next cycle with no buffering. If the new value is below the count, no match occurs until the counter has passed 0xFF and wrapped.
- R7: With output mode code 1, the waveform output inverts in the cycle after each compare-match tick. With codes 0, 2 and 3 it holds its level.
- R8: A 10-bit prescaler counts every clock from reset. Clock select codes 1, 2, 3, 4 and 5 give divide-by 1, 8, 64, 256 and 1024. A tick occurs on clocks where the low log2(N) prescaler bits are all ones. Codes 0, 6 and 7 stop the timer: the count holds and no flag is set.
- R9: A counter write loads the value on the next cycle. It overrides the tick in that cycle and suppresses that tick's compare match, overflow and toggle.
- R10: In clear-on-compare mode with toggling, the output frequency is clk / (2 × N × (1 + compare)). With compare 0 and divide-by 1 this is half the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkSel | input | 3 | Prescaler select (0 and 6..7 stop the timer) |
| modeSel | input | 2 | Counting mode (2 = clear on compare) |
| outMode | input | 2 | Waveform output mode (1 = toggle on match) |
| cntWrEn | input | 1 | Counter write strobe |
| cntWrData | input | 8 | Counter write value |
| cmpWrEn | input | 1 | Compare register write strobe |
| cmpWrData | input | 8 | Compare register write value |
| ovfClr | input | 1 | Overflow flag acknowledge |
| cmpClr | input | 1 | Compare flag acknowledge |
| cnt | output | 8 | Current count |
| cmpVal | output | 8 | Current compare register |
| ovfFlag | output | 1 | Sticky overflow flag |
| cmpFlag | output | 1 | Sticky compare-match flag |
| waveOut | output | 1 | Waveform output |

## Verification
The hardest case to reach is the missed match. It needs a compare value written below a count that is already further along, so the counter has to run through 0xFF before the match can fire. The stimulus sets this up directly by loading the counter and the compare register in the same cycle. A second hard case is a flag set that coincides with an acknowledge. Here the counter is loaded just below 0xFF and the acknowledges are held high across the wrap. Random phases then mix counter loads, compare writes and acknowledges with ticks, and a behavioural model checks every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_DIV = 5;
  // log2 of each divide ratio, in clock-select order 1..5
  localparam int DIV_SHIFT [NUM_DIV] = '{0, 3, 6, 8, 10};
  localparam int PRE_BITS = 10;

  localparam logic [1:0] MODE_CLR_ON_MATCH = 2'd2;
  localparam logic [1:0] OUT_TOGGLE = 2'd1;

  typedef struct packed {
    logic tick;
    logic load;
    logic cmpLoad;
    logic clrOnMatch;
    logic toggleOnMatch;
    logic ovfAck;
    logic cmpAck;
  } tmr_strobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] clkSel,
  input  logic [1:0]       modeSel,
  input  logic [1:0]       outMode,
  input  logic             cntWrEn,
  input  logic             cmpWrEn,
  input  logic             ovfClr,
  input  logic             cmpClr,
  output tmr_strobe_t      strb
);
  logic [PRE_BITS-1:0] preCnt;
  logic [NUM_DIV-1:0]  tap;
  logic                tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_tap
    if (DIV_SHIFT[i] == 0) begin : g_every
      assign tap[i] = 1'b1;
    end else begin : g_div
      assign tap[i] = &preCnt[DIV_SHIFT[i]-1:0];
    end
  end

  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NUM_DIV; i++) begin
      if (clkSel == SEL_W'(i + 1)) tick = tap[i];
    end
  end

  always_comb begin
    strb.tick          = tick;
    strb.load          = cntWrEn;
    strb.cmpLoad       = cmpWrEn;
    strb.clrOnMatch    = (modeSel == MODE_CLR_ON_MATCH);
    strb.toggleOnMatch = (outMode == OUT_TOGGLE);
    strb.ovfAck        = ovfClr;
    strb.cmpAck        = cmpClr;
  end

  AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == '0 || clkSel > SEL_W'(NUM_DIV)) |-> !strb.tick); // R8
  AST_DIV8_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == SEL_W'(2) && strb.tick) |=> !strb.tick); // R8
endmodule

// File: rtl/tmr_dp.sv
module tmr_dp
  import tmr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmr_strobe_t      strb,
  input  logic [WIDTH-1:0] cntWrData,
  input  logic [WIDTH-1:0] cmpWrData,
  output logic [WIDTH-1:0] cnt,
  output logic [WIDTH-1:0] cmpVal,
  output logic             ovfFlag,
  output logic             cmpFlag,
  output logic             waveOut
);
  localparam logic [WIDTH-1:0] TOP_VAL = '1;

  logic [WIDTH-1:0] cntQ, cmpQ;
  logic             ovfQ, cmpFQ, waveQ;
  logic             step, hit, wrap;

  assign step = strb.tick && !strb.load;
  assign hit  = step && (cntQ == cmpQ);
  assign wrap = step && (cntQ == TOP_VAL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strb.load) begin
      cntQ <= cntWrData;
    end else if (hit && strb.clrOnMatch) begin
      cntQ <= '0;
    end else if (step) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cmpQ <= '0;
    else if (strb.cmpLoad) cmpQ <= cmpWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfQ  <= 1'b0;
      cmpFQ <= 1'b0;
      waveQ <= 1'b0;
    end else begin
      if (wrap)             ovfQ <= 1'b1;
      else if (strb.ovfAck) ovfQ <= 1'b0;
      if (hit)              cmpFQ <= 1'b1;
      else if (strb.cmpAck) cmpFQ <= 1'b0;
      if (hit && strb.toggleOnMatch) waveQ <= !waveQ;
    end
  end

  assign cnt     = cntQ;
  assign cmpVal  = cmpQ;
  assign ovfFlag = ovfQ;
  assign cmpFlag = cmpFQ;
  assign waveOut = waveQ;

  AST_CLR_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (step && strb.clrOnMatch && cntQ == cmpQ) |=> (cntQ == '0)); // R3
  AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (step && cntQ == TOP_VAL) |=> ovfQ); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfQ && !strb.ovfAck) |=> ovfQ); // R4
  AST_CMP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (cmpFQ && !strb.cmpAck) |=> cmpFQ); // R5
  AST_WAVE_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (step && strb.toggleOnMatch && cntQ == cmpQ) |=> (waveQ != $past(waveQ))); // R7
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (cntQ == $past(cntWrData))); // R9
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tick && !strb.load) |=> $stable(cntQ)); // R8
endmodule

// File: rtl/ctc_timer.sv
module ctc_timer
  import tmr_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] clkSel,
  input  logic [1:0]       modeSel,
  input  logic [1:0]       outMode,
  input  logic             cntWrEn,
  input  logic [WIDTH-1:0] cntWrData,
  input  logic             cmpWrEn,
  input  logic [WIDTH-1:0] cmpWrData,
  input  logic             ovfClr,
  input  logic             cmpClr,
  output logic [WIDTH-1:0] cnt,
  output logic [WIDTH-1:0] cmpVal,
  output logic             ovfFlag,
  output logic             cmpFlag,
  output logic             waveOut
);
  tmr_strobe_t strb;

  tmr_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .clkSel  (clkSel),
    .modeSel (modeSel),
    .outMode (outMode),
    .cntWrEn (cntWrEn),
    .cmpWrEn (cmpWrEn),
    .ovfClr  (ovfClr),
    .cmpClr  (cmpClr),
    .strb    (strb)
  );

  tmr_dp #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cntWrData (cntWrData),
    .cmpWrData (cmpWrData),
    .cnt       (cnt),
    .cmpVal    (cmpVal),
    .ovfFlag   (ovfFlag),
    .cmpFlag   (cmpFlag),
    .waveOut   (waveOut)
  );
endmodule

// File: tb/ctc_timer_tb.sv
module ctc_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] clkSel = '0;
  logic [1:0] modeSel = '0;
  logic [1:0] outMode = '0;
  logic       cntWrEn = 1'b0;
  logic [7:0] cntWrData = '0;
  logic       cmpWrEn = 1'b0;
  logic [7:0] cmpWrData = '0;
  logic       ovfClr = 1'b0;
  logic       cmpClr = 1'b0;
  logic [7:0] cnt, cmpVal;
  logic       ovfFlag, cmpFlag, waveOut;

  int vectors = 0;
  int miscompares = 0;
  string phaseTag = "R1";

  // behavioural reference state
  int mCnt = 0, mCmp = 0, mOvf = 0, mCmpF = 0, mWave = 0, mPre = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ctc_timer u_dut (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .modeSel(modeSel), .outMode(outMode),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData), .cmpWrEn(cmpWrEn), .cmpWrData(cmpWrData),
    .ovfClr(ovfClr), .cmpClr(cmpClr), .cnt(cnt), .cmpVal(cmpVal),
    .ovfFlag(ovfFlag), .cmpFlag(cmpFlag), .waveOut(waveOut)
  );

  function automatic int divOf(input int sel);
    case (sel)
      1: return 1;
      2: return 8;
      3: return 64;
      4: return 256;
      5: return 1024;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int n;
    bit tk, match;
    if (!rstN) begin
      mCnt = 0; mCmp = 0; mOvf = 0; mCmpF = 0; mWave = 0; mPre = 0;
    end else begin
      n  = divOf(int'(clkSel));
      tk = (n > 0) && ((mPre % n) == n - 1);
      mPre = (mPre + 1) % 1024;
      if (cntWrEn) begin
        mCnt = int'(cntWrData);
        if (cmpClr) mCmpF = 0;
        if (ovfClr) mOvf = 0;
      end else begin
        match = tk && (mCnt == mCmp);
        if (tk && mCnt == 255) mOvf = 1; else if (ovfClr) mOvf = 0;
        if (match) mCmpF = 1; else if (cmpClr) mCmpF = 0;
        if (match && outMode == 2'd1) mWave = 1 - mWave;
        if (tk) mCnt = (match && modeSel == 2'd2) ? 0 : (mCnt + 1) % 256;
      end
      if (cmpWrEn) mCmp = int'(cmpWrData);
    end
  end

  task automatic chk(input string sig, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", phaseTag, sig, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("cnt", int'(cnt), mCnt);
    chk("cmpVal", int'(cmpVal), mCmp);
    chk("ovfFlag", int'(ovfFlag), mOvf);
    chk("cmpFlag", int'(cmpFlag), mCmpF);
    chk("waveOut", int'(waveOut), mWave);
  endtask

  task automatic step(input bit cw, input int cd, input bit mw, input int md,
                      input bit oc, input bit cc);
    @(negedge clk);
    compareAll();
    cntWrEn = cw; cntWrData = 8'(cd);
    cmpWrEn = mw; cmpWrData = 8'(md);
    ovfClr = oc; cmpClr = cc;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset values with the timer stopped
    phaseTag = "R1";
    idle(3);
    // R2: free-running mode, compare at 0x40 does not clear
    phaseTag = "R2";
    clkSel = 3'd1; modeSel = 2'd0; outMode = 2'd1;
    step(0, 0, 1, 8'h40, 0, 0);
    idle(300);
    modeSel = 2'd3;
    idle(280);
    // R4: set wins over an acknowledge held across the wrap
    phaseTag = "R4";
    step(1, 8'hFD, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 600; i++) step(0, 0, 0, 0, (i % 97) == 0, 0);
    // R5: compare flag, acknowledge held across a match
    phaseTag = "R5";
    step(1, 8'h3E, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 600; i++) step(0, 0, 0, 0, 0, (i % 53) == 0);
    // R3: clear on compare at 9
    phaseTag = "R3";
    modeSel = 2'd2;
    step(1, 0, 1, 9, 1, 1);
    idle(100);
    // R6: compare written below the count -> runs to 0xFF first
    phaseTag = "R6";
    step(1, 8'h50, 1, 8'h20, 1, 1);
    idle(300);
    // R7: output modes other than toggle hold the level
    phaseTag = "R7";
    outMode = 2'd0; idle(60);
    outMode = 2'd2; idle(60);
    outMode = 2'd3; idle(60);
    outMode = 2'd1; idle(60);
    // R10: output frequency, compare 0 at divide-by 1, then compare 3 at divide-by 8
    phaseTag = "R10";
    step(1, 0, 1, 0, 0, 0);
    idle(20);
    clkSel = 3'd2;
    step(0, 0, 1, 3, 0, 0);
    idle(200);
    // R8: larger dividers and stopped codes
    phaseTag = "R8";
    modeSel = 2'd0;
    clkSel = 3'd3; idle(600);
    clkSel = 3'd4; idle(1200);
    clkSel = 3'd5; idle(3000);
    clkSel = 3'd0; step(1, 8'hFF, 1, 8'hFF, 0, 0); idle(50);
    clkSel = 3'd6; idle(50);
    clkSel = 3'd7; idle(50);
    // R9: loads mixed with ticks, writes and acknowledges
    phaseTag = "R9";
    for (int i = 0; i < 3000; i++) begin
      if (i % 200 == 0) begin
        modeSel = 2'($urandom_range(0, 3));
        clkSel  = 3'($urandom_range(1, 2));
      end
      step(($urandom % 16) == 0, $urandom % 256,
           ($urandom % 64) == 0, $urandom % 256,
           ($urandom % 8) == 0, ($urandom % 8) == 0);
    end
    @(negedge clk);
    compareAll();
    summary();
    $finish;
  end
endmodule